// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Engine

This block turns a protocol-engine clock into CAN bit timing. A programmable prescaler divides the engine clock down to a time-quantum tick. A sequencer then walks every bit time through four segments in order: sync, propagation, phase one and phase two. It emits a one-cycle sample strobe where phase one ends and a one-cycle transmit-point strobe where a new bit begins. The receive line is synchronized and watched for recessive-to-dominant transitions. On an idle bus such a transition restarts the bit (hard synchronization). During a frame it stretches phase one or trims phase two by no more than the programmed jump width, at most once per bit.

A 20-bit configuration word holds the timing fields and a loop-back enable. The timing fields change only while the freeze input is high. The loop-back enable can change at any time. In loop-back the transmit pin is parked recessive and the internal transmit stream feeds the receive path in place of the external pin. The surrounding protocol engine supplies `tx_bit` and `bus_idle`, and it consumes the strobes and `rx_bit`.

Top module: `can_bittime_gen`

## Requirements
- R1: `tq_tick` is high one cycle in every DIV+1 engine cycles, where DIV is bits [7:0] of the configuration word. After reset DIV is 0, so `tq_tick` is high every cycle.
- R2: A bit time lasts 1 + (PROP+1) + (P1+1) + (P2+1) quanta. PROP is bits [10:8], P1 is bits [13:11] and P2 is bits [16:14]. `sample_pulse` is high for one cycle after the tick that ends phase one. `txpt_pulse` is high for one cycle after the tick that ends phase two, and it is never high together with `sample_pulse`.
- R3: The configuration word has this layout: DIV [7:0], PROP [10:8], P1 [13:11], P2 [16:14], JW [18:17], loop-back enable [19]. It reads back on `cfg_rdata`. The reset value has every field 0 except P2, which is 1.
- R4: A write with `freeze` low leaves DIV, PROP, P1, P2 and JW unchanged.
- R5: A P2 value of 0 in any write is rejected and the previous P2 is kept. The other fields of the same write still take effect.
- R6: The loop-back bit can be written whatever the state of `freeze`. With loop-back off, `tx_pin` follows `tx_bit` one cycle later and `rx_bit` follows `rx_pin` two cycles later. With loop-back on, `tx_pin` is 1, `rx_pin` has no effect, and `rx_bit` follows `tx_bit` two cycles later.
- R7: A recessive-to-dominant edge seen while `bus_idle` is high restarts the bit at the end of its sync segment and resets the prescaler. The next sample strobe follows (PROP+1)+(P1+1) quanta later.
- R8: A falling edge seen in the propagation segment or in phase one, with `bus_idle` low, lengthens phase one by min(e, JW+1) quanta. Here e is the number of quanta elapsed since the start of the sync segment.
- R9: A falling edge seen in phase two, with `bus_idle` low, cuts the quanta left after the current one by min(left, JW+1).
- R10: At most one resynchronization is applied per bit time. Later edges in the same bit have no effect.
- R11: Rising edges, and falling edges that land in the sync segment, leave the bit timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Unlocks the timing fields for writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 20 | Configuration write data |
| cfg_rdata | output | 20 | Current configuration word |
| bus_idle | input | 1 | Bus idle indication from the protocol engine |
| tx_bit | input | 1 | Transmit bit stream from the protocol engine |
| tx_pin | output | 1 | Transmit line |
| rx_pin | input | 1 | Receive line |
| rx_bit | output | 1 | Synchronized receive bit |
| tq_tick | output | 1 | Time-quantum tick |
| sample_pulse | output | 1 | Sample point strobe |
| txpt_pulse | output | 1 | Transmit point strobe |

## Verification
With a divide ratio of one, every engine cycle is a quantum tick. A detected edge therefore always meets a segment-boundary decision in the same cycle. The bench places edges at chosen offsets from a sample strobe: on the last quantum of phase one, inside the propagation segment, and partway into phase two. In each case the resynchronization must take effect before the boundary decision in that same cycle. The result is judged only by the spacing of consecutive sample strobes, which must grow or shrink by exactly the capped phase error. A hard synchronization is also forced while the prescaler is mid-count, to show that the restart wins over the running divider.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int PRESC_W = 8;
  localparam int SEG_W   = 3;
  localparam int SJW_W   = 2;

  typedef enum logic [1:0] {SEG_SYNC, SEG_PROP, SEG_PH1, SEG_PH2} seg_e;

  typedef struct packed {
    logic               lpbk;
    logic [SJW_W-1:0]   sjw;
    logic [SEG_W-1:0]   ph2;
    logic [SEG_W-1:0]   ph1;
    logic [SEG_W-1:0]   prop;
    logic [PRESC_W-1:0] presc;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] div,
  output logic         tick
);
  logic [W-1:0] cnt_q;

  assign tick = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (restart)      cnt_q <= div;
    else if (cnt_q == '0)  cnt_q <= div;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  // R1: with a divide of one, a tick is followed by another tick
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && div == '0) |=> tick);
endmodule

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
  import cbt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic freeze,
  input  logic we,
  input  cfg_t wdata,
  output cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg.lpbk  <= 1'b0;
      cfg.sjw   <= '0;
      cfg.ph2   <= SEG_W'(1);
      cfg.ph1   <= '0;
      cfg.prop  <= '0;
      cfg.presc <= '0;
    end else if (we) begin
      cfg.lpbk <= wdata.lpbk;
      if (freeze) begin
        cfg.presc <= wdata.presc;
        cfg.prop  <= wdata.prop;
        cfg.ph1   <= wdata.ph1;
        cfg.sjw   <= wdata.sjw;
        if (wdata.ph2 != '0) cfg.ph2 <= wdata.ph2;
      end
    end
  end

  p_locked_r4: assert property (@(posedge clk) disable iff (rst)
    !freeze |=> ($stable(cfg.presc) && $stable(cfg.prop) && $stable(cfg.ph1)
                 && $stable(cfg.ph2) && $stable(cfg.sjw)));

  p_ph2_legal_r5: assert property (@(posedge clk) disable iff (rst)
    cfg.ph2 != '0);
endmodule

// File: rtl/cbt_line_if.sv
module cbt_line_if (
  input  logic clk,
  input  logic rst,
  input  logic lpbk,
  input  logic tx_bit,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_bit,
  output logic fall
);
  logic src, s1_q, s2_q, s3_q;

  assign src    = lpbk ? tx_bit : rx_pin;
  assign rx_bit = s2_q;
  assign fall   = s3_q & ~s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      s3_q   <= 1'b1;
      tx_pin <= 1'b1;
    end else begin
      s1_q   <= src;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      tx_pin <= lpbk ? 1'b1 : tx_bit;
    end
  end

  // R6: loop-back parks the transmit line recessive
  p_lpbk_tx_r6: assert property (@(posedge clk) disable iff (rst)
    lpbk |=> tx_pin);
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
  import cbt_pkg::*;
#(
  parameter int SW = SEG_W,
  parameter int JW = SJW_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          fall,
  input  logic          bus_idle,
  input  logic [SW-1:0] prop,
  input  logic [SW-1:0] ph1,
  input  logic [SW-1:0] ph2,
  input  logic [JW-1:0] sjw,
  output logic          hard_sync,
  output logic          sample_pulse,
  output logic          txpt_pulse
);
  localparam int CW = SW + 2;

  seg_e          seg_q, seg_n;
  logic [CW-1:0] cnt_q, cnt_n, cnt_adj, e_q, e_n, pend_q, pend_n;
  logic [CW-1:0] jump, ext, cut;
  logic          rs_q, rs_n, resync, smp_n, txp_n;

  always_comb begin
    jump      = CW'(sjw) + CW'(1);
    ext       = (e_q > jump) ? jump : e_q;
    cut       = (cnt_q > jump) ? jump : cnt_q;
    hard_sync = fall & bus_idle;
    resync    = fall & ~bus_idle & ~rs_q & (seg_q != SEG_SYNC);
    cnt_adj   = cnt_q;
    pend_n    = pend_q;
    rs_n      = rs_q | resync;
    if (resync) begin
      case (seg_q)
        SEG_PROP: pend_n  = ext;
        SEG_PH1:  cnt_adj = cnt_q + ext;
        SEG_PH2:  cnt_adj = cnt_q - cut;
        default:  ;
      endcase
    end
    seg_n = seg_q;
    cnt_n = cnt_adj;
    e_n   = e_q;
    smp_n = 1'b0;
    txp_n = 1'b0;
    if (hard_sync) begin
      seg_n  = SEG_PROP;
      cnt_n  = CW'(prop);
      e_n    = CW'(1);
      pend_n = '0;
      rs_n   = 1'b1;
    end else if (tick) begin
      e_n = e_q + CW'(1);
      if (cnt_adj != '0) begin
        cnt_n = cnt_adj - CW'(1);
      end else begin
        case (seg_q)
          SEG_SYNC: begin seg_n = SEG_PROP; cnt_n = CW'(prop); end
          SEG_PROP: begin seg_n = SEG_PH1; cnt_n = CW'(ph1) + pend_n; pend_n = '0; end
          SEG_PH1:  begin seg_n = SEG_PH2; cnt_n = CW'(ph2); smp_n = 1'b1; end
          default:  begin
            seg_n = SEG_SYNC; cnt_n = '0; e_n = '0; rs_n = 1'b0; txp_n = 1'b1;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q        <= SEG_SYNC;
      cnt_q        <= '0;
      e_q          <= '0;
      pend_q       <= '0;
      rs_q         <= 1'b0;
      sample_pulse <= 1'b0;
      txpt_pulse   <= 1'b0;
    end else begin
      seg_q        <= seg_n;
      cnt_q        <= cnt_n;
      e_q          <= e_n;
      pend_q       <= pend_n;
      rs_q         <= rs_n;
      sample_pulse <= smp_n;
      txpt_pulse   <= txp_n;
    end
  end

  p_pulse_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(sample_pulse && txpt_pulse));

  p_hard_sync_r7: assert property (@(posedge clk) disable iff (rst)
    hard_sync |=> (seg_q == SEG_PROP && e_q == CW'(1)));

  // R10: once a bit has resynchronized, further edges leave the count alone
  p_one_resync_r10: assert property (@(posedge clk) disable iff (rst)
    (fall && rs_q && !bus_idle && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/can_bittime_gen.sv
module can_bittime_gen
  import cbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             freeze,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             bus_idle,
  input  logic             tx_bit,
  output logic             tx_pin,
  input  logic             rx_pin,
  output logic             rx_bit,
  output logic             tq_tick,
  output logic             sample_pulse,
  output logic             txpt_pulse
);
  cfg_t cfg;
  logic fall, hard_sync;

  assign cfg_rdata = cfg;

  cbt_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .freeze(freeze), .we(cfg_we),
    .wdata(cfg_t'(cfg_wdata)), .cfg(cfg)
  );

  cbt_prescaler #(.W(PRESC_W)) u_presc (
    .clk(clk), .rst(rst), .restart(hard_sync), .div(cfg.presc), .tick(tq_tick)
  );

  cbt_line_if u_line (
    .clk(clk), .rst(rst), .lpbk(cfg.lpbk), .tx_bit(tx_bit), .rx_pin(rx_pin),
    .tx_pin(tx_pin), .rx_bit(rx_bit), .fall(fall)
  );

  cbt_seq #(.SW(SEG_W), .JW(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tq_tick), .fall(fall), .bus_idle(bus_idle),
    .prop(cfg.prop), .ph1(cfg.ph1), .ph2(cfg.ph2), .sjw(cfg.sjw),
    .hard_sync(hard_sync), .sample_pulse(sample_pulse), .txpt_pulse(txpt_pulse)
  );
endmodule

// File: tb/can_bittime_gen_tb_top.sv
module can_bittime_gen_tb_top;
  import cbt_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1, freeze = 1'b0, cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0, cfg_rdata;
  logic bus_idle = 1'b0, tx_bit = 1'b1, rx_pin = 1'b1;
  logic tx_pin, rx_bit, tq_tick, sample_pulse, txpt_pulse;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  can_bittime_gen dut_i (
    .clk(clk), .rst(rst), .freeze(freeze), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .bus_idle(bus_idle), .tx_bit(tx_bit), .tx_pin(tx_pin),
    .rx_pin(rx_pin), .rx_bit(rx_bit), .tq_tick(tq_tick),
    .sample_pulse(sample_pulse), .txpt_pulse(txpt_pulse)
  );

  function automatic logic [CFG_W-1:0] mk(input logic lp, input logic [1:0] jw,
      input logic [2:0] p2, input logic [2:0] p1, input logic [2:0] pr, input logic [7:0] dv);
    return {lp, jw, p2, p1, pr, dv};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [CFG_W-1:0] w, input logic frz);
    @(negedge clk);
    freeze = frz; cfg_we = 1'b1; cfg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; freeze = 1'b0;
  endtask

  task automatic wait_sample();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (sample_pulse) break;
    end
  endtask

  // counts posedges from one sample strobe to the next; drives up to three line changes
  task automatic measure(input int sel, input int d1, input logic v1, input int d2,
      input logic v2, input int d3, input logic v3, output int n);
    wait_sample();
    n = -1;
    for (int i = 1; i < 2000; i++) begin
      if (i - 1 == d1) begin if (sel == 0) tx_bit = v1; else rx_pin = v1; end
      if (i - 1 == d2) begin if (sel == 0) tx_bit = v2; else rx_pin = v2; end
      if (i - 1 == d3) begin if (sel == 0) tx_bit = v3; else rx_pin = v3; end
      @(posedge clk);
      @(negedge clk);
      if (sample_pulse) begin n = i; break; end
    end
  endtask

  task automatic settle();
    tx_bit = 1'b1;
    wait_sample();
    wait_sample();
  endtask

  task automatic t_reset();
    int cnt = 0;
    chk("R3 reset word", int'(cfg_rdata), int'(mk(0, 0, 1, 0, 0, 0)));
    chk("R6 reset tx_pin", int'(tx_pin), 1);
    chk("R6 reset rx_bit", int'(rx_bit), 1);
    chk("R2 reset sample", int'(sample_pulse), 0);
    for (int i = 0; i < 5; i++) begin
      if (tq_tick) cnt++;
      @(negedge clk);
    end
    chk("R1 reset tick every cycle", cnt, 5);
  endtask

  task automatic t_nominal();
    int n, cnt = 0;
    cfg_write(mk(0, 0, 3, 2, 1, 2), 1'b1);
    chk("R3 readback", int'(cfg_rdata), int'(mk(0, 0, 3, 2, 1, 2)));
    settle();
    measure(0, -1, 1'b1, -1, 1'b1, -1, 1'b1, n);
    chk("R2 bit time 10 quanta x3", n, 30);
    n = 0;
    for (int i = 1; i < 100; i++) begin
      @(posedge clk); @(negedge clk);
      if (txpt_pulse) begin n = i; break; end
    end
    chk("R2 sample to txpt", n, 12);
    for (int i = 0; i < 30; i++) begin
      if (tq_tick) cnt++;
      @(negedge clk);
    end
    chk("R1 ticks per 30 cycles at div 3", cnt, 10);
  endtask

  task automatic t_lock();
    logic [CFG_W-1:0] a;
    a = cfg_rdata;
    cfg_write(mk(1, 3, 6, 5, 4, 9), 1'b0);
    chk("R4 fields locked", int'(cfg_rdata), int'({1'b1, a[CFG_W-2:0]}));
    tx_bit = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 lpbk tx_pin recessive", int'(tx_pin), 1);
    tx_bit = 1'b1;
    cfg_write(a, 1'b1);
  endtask

  task automatic t_ph2_zero();
    cfg_write(mk(0, 0, 0, 2, 1, 5), 1'b1);
    chk("R5 zero P2 rejected", int'(cfg_rdata), int'(mk(0, 0, 3, 2, 1, 5)));
    cfg_write(mk(0, 0, 3, 2, 1, 2), 1'b1);
  endtask

  task automatic t_loopback();
    int n;
    tx_bit = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 tx_pin follows tx_bit", int'(tx_pin), 0);
    tx_bit = 1'b1; rx_pin = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 rx_bit not yet", int'(rx_bit), 1);
    @(posedge clk); @(negedge clk);
    chk("R6 rx_bit follows rx_pin", int'(rx_bit), 0);
    rx_pin = 1'b1;
    cfg_write(mk(1, 0, 3, 2, 1, 2), 1'b0);
    chk("R6 lpbk writable unfrozen", int'(cfg_rdata), int'(mk(1, 0, 3, 2, 1, 2)));
    tx_bit = 1'b0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R6 rx_bit from tx_bit", int'(rx_bit), 0);
    chk("R6 tx_pin held 1", int'(tx_pin), 1);
    settle();
    bus_idle = 1'b1;
    measure(1, 0, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R6 rx_pin ignored in loop-back", n, 30);
    rx_pin = 1'b1;
    bus_idle = 1'b0;
  endtask

  task automatic t_hard_sync();
    int n = 0;
    cfg_write(mk(1, 0, 2, 3, 0, 1), 1'b1);
    settle();
    bus_idle = 1'b1;
    wait_sample();
    repeat (3) @(negedge clk);
    tx_bit = 1'b0;
    for (int i = 1; i < 200; i++) begin
      @(posedge clk); @(negedge clk);
      if (sample_pulse) begin n = i; break; end
    end
    chk("R7 hard sync to sample", n, 13);
    bus_idle = 1'b0;
    tx_bit = 1'b1;
  endtask

  task automatic t_resync();
    int n;
    cfg_write(mk(1, 1, 2, 3, 0, 0), 1'b1);
    settle();
    measure(0, -1, 1'b1, -1, 1'b1, -1, 1'b1, n);
    chk("R2 nominal 9", n, 9);
    measure(0, 5, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R8 lengthen capped at 2", n, 11);
    measure(0, 5, 1'b1, -1, 1'b1, -1, 1'b1, n);
    chk("R11 rising edge ignored", n, 9);
    measure(0, 2, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R8 edge in propagation", n, 10);
    settle();
    measure(0, 1, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R11 edge in sync ignored", n, 9);
    cfg_write(mk(1, 3, 2, 3, 0, 0), 1'b1);
    settle();
    measure(0, 4, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R8 lengthen by error 3", n, 12);
    settle();
    measure(0, 4, 1'b0, 5, 1'b1, 6, 1'b0, n);
    chk("R10 second edge ignored", n, 12);
    cfg_write(mk(1, 1, 4, 3, 0, 0), 1'b1);
    settle();
    measure(0, -1, 1'b1, -1, 1'b1, -1, 1'b1, n);
    chk("R2 nominal 11", n, 11);
    measure(0, 0, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R9 shorten capped at 2", n, 9);
    cfg_write(mk(1, 3, 4, 3, 0, 0), 1'b1);
    settle();
    measure(0, 1, 1'b0, -1, 1'b1, -1, 1'b1, n);
    chk("R9 shorten by remaining 1", n, 10);
    tx_bit = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_nominal();
    t_lock();
    t_ph2_zero();
    t_loopback();
    t_hard_sync();
    t_resync();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule